// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog

This block is a watchdog counter for supervising software. It is programmed through one control word, written over a single-cycle write port. The word carries three fields:

- a 7-bit key;
- a run bit;
- a reload count.

Once the run bit of an accepted word is set, the watchdog is armed. From then on, software can only change it by writing a word whose key field is the bitwise inverse of the key stored by the previous accepted write.

The count moves down by one on each cycle in which the external tick-enable input is high. The block has two escalation stages:

- **First expiry.** The non-maskable interrupt output is raised. The counter then reloads a short grace count and keeps running.
- **Second expiry, no service in between.** A one-cycle system reset request is issued and counting halts.

Servicing the watchdog means making an accepted write. An accepted write drops the interrupt and restarts the escalation from the first stage. The tick source lies outside the block.

Top module: `wdog_escalator`

## Requirements
- R1: After synchronous reset, `nmi` and `rst_req` are 0, the watchdog is disarmed, and the stored key is 0.
- R2: While disarmed (the stored run bit is 0), any write is accepted, whatever its key field.
- R3: While armed, a write is discarded unless its key field (`wr_data[15:9]`) equals the 7-bit bitwise inverse of the stored key. A discarded write changes nothing, including `nmi` and the running count.
- R4: An accepted write with run bit `wr_data[8]` = 1 loads the reload count `wr_data[7:0]` and arms the counter. `nmi` rises after exactly that many ticks.
- R5: A reload count field of 0 means 256 ticks.
- R6: An accepted write with run bit 0 stops the counter and disarms the watchdog. No expiry follows, however many ticks arrive.
- R7: An accepted write clears `nmi` and the expiry history, so the next expiry is treated as a first expiry again.
- R8: On the first expiry, `nmi` is set and the counter reloads `GRACE` ticks (default 10) and keeps counting.
- R9: On an expiry that follows an unserviced first expiry, `rst_req` is high for exactly one cycle. Counting then stops, and `nmi` stays high.
- R10: The count changes only in cycles where `tick` is 1. When a write and a tick occur in the same cycle, an accepted write takes precedence over the tick.
- R11: The key of each accepted write becomes the reference for the next inverse-key check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control word write strobe, one cycle per write |
| wr_data | input | 16 | Control word: key [15:9], run [8], reload count [7:0] |
| tick | input | 1 | Count enable, one cycle per tick |
| nmi | output | 1 | Non-maskable interrupt, level |
| rst_req | output | 1 | System reset request, one-cycle pulse |

## Verification
The bench targets the boundaries of the expiry count:

- A count of N must expire on exactly the Nth tick. An off-by-one design would raise `nmi` one tick early or late.
- A zero count must run for 256 ticks. A design that misreads zero would expire at once or never.

Key protection is probed in two ways:

- A wrong key is written while `nmi` is high. A design that accepted it would clear `nmi`.
- The previous key is replayed after a successful write. A design that kept the old reference would accept the replay.

Escalation is followed through the grace window to the reset pulse and beyond. This catches a design that issues the reset pulse on the first expiry, holds `rst_req` for more than one cycle, or keeps counting after the reset pulse. It also catches a design that lets a tick in the same cycle corrupt a freshly loaded count.

// File: rtl/wdog_escalator.sv
module wdog_escalator #(
  parameter int KEY_W = 7,
  parameter int CNT_W = 8,
  parameter int GRACE = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [KEY_W+CNT_W:0]   wr_data,
  input  logic                   tick,
  output logic                   nmi,
  output logic                   rst_req
);
  localparam int WORD_W = KEY_W + 1 + CNT_W;
  localparam int LOAD_W = CNT_W + 1;
  localparam logic [LOAD_W-1:0] FULL_LOAD  = LOAD_W'(1 << CNT_W);
  localparam logic [LOAD_W-1:0] GRACE_LOAD = LOAD_W'(GRACE);

  logic [KEY_W-1:0]  key_q;
  logic              armed_q;
  logic              active_q;
  logic              hit_q;
  logic [LOAD_W-1:0] cnt_q;
  logic              nmi_q;
  logic              rreq_q;

  wire [KEY_W-1:0] key_in = wr_data[WORD_W-1 -: KEY_W];
  wire             run_in = wr_data[CNT_W];
  wire [CNT_W-1:0] cnt_in = wr_data[CNT_W-1:0];

  wire             accept = wr_en && (!armed_q || key_in == ~key_q);
  wire [LOAD_W-1:0] reload = (cnt_in == '0) ? FULL_LOAD : {1'b0, cnt_in};
  wire             step   = active_q && tick;
  wire             expire = step && cnt_q == LOAD_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q    <= '0;
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      hit_q    <= 1'b0;
      cnt_q    <= '0;
      nmi_q    <= 1'b0;
      rreq_q   <= 1'b0;
    end else begin
      rreq_q <= 1'b0;
      if (accept) begin
        key_q    <= key_in;
        armed_q  <= run_in;
        active_q <= run_in;
        hit_q    <= 1'b0;
        nmi_q    <= 1'b0;
        if (run_in) cnt_q <= reload;
      end else if (expire) begin
        if (!hit_q) begin
          nmi_q <= 1'b1;
          hit_q <= 1'b1;
          cnt_q <= GRACE_LOAD;
        end else begin
          rreq_q   <= 1'b1;
          active_q <= 1'b0;
        end
      end else if (step) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign nmi     = nmi_q;
  assign rst_req = rreq_q;

  // R9
  rreq_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R9
  rreq_after_nmi_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> nmi && !active_q);

  // R8
  nmi_first_stage_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi) |-> $past(!hit_q) && hit_q && cnt_q == GRACE_LOAD && active_q);

  // R7
  service_clears_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !nmi && !hit_q);

  // R3
  bad_key_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && armed_q && key_in != ~key_q) |=> $stable(key_q) && $stable(nmi));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !wr_en) |=> $stable(cnt_q) && !$rose(nmi));

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> $stable(cnt_q) && $stable(nmi));
endmodule

// File: tb/wdog_escalator_test.sv
module wdog_escalator_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic tick = 1'b0;
  logic nmi, rst_req;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string phase = "R1";

  int m_key = 0, m_armed = 0, m_active = 0, m_hit = 0, m_cnt = 0, m_nmi = 0, m_rreq = 0;

  always #2.5 clk = ~clk;

  wdog_escalator uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .tick(tick), .nmi(nmi), .rst_req(rst_req)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_key = 0; m_armed = 0; m_active = 0; m_hit = 0; m_cnt = 0; m_nmi = 0; m_rreq = 0;
    end else begin
      int k;
      k = wr_data[15:9];
      m_rreq = 0;
      if (wr_en && (m_armed == 0 || k == ((~m_key) & 127))) begin
        m_key = k;
        m_armed = wr_data[8];
        m_active = wr_data[8];
        m_hit = 0;
        m_nmi = 0;
        if (wr_data[8]) m_cnt = (wr_data[7:0] == 0) ? 256 : wr_data[7:0];
      end else if (m_active != 0 && tick) begin
        if (m_cnt == 1) begin
          if (m_hit == 0) begin
            m_nmi = 1; m_hit = 1; m_cnt = 10;
          end else begin
            m_rreq = 1; m_active = 0;
          end
        end else m_cnt = m_cnt - 1;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      compared++;
      if (nmi !== m_nmi[0] || rst_req !== m_rreq[0]) begin
        mismatched++;
        $display("FAIL %s cycle %0d: nmi=%b rst_req=%b expected nmi=%0d rst_req=%0d",
                 phase, cycles, nmi, rst_req, m_nmi, m_rreq);
      end
    end
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog expired (all requirements)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic write(input int key, input bit run, input int cnt, input bit with_tick);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {key[6:0], run, cnt[7:0]};
    tick = with_tick;
    @(negedge clk);
    wr_en = 1'b0;
    tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    phase = "R1";
    check("R1", nmi, 1'b0, "nmi after reset");
    check("R1", rst_req, 1'b0, "rst_req after reset");

    phase = "R2";
    write(7'h15, 1'b1, 5, 1'b0);
    phase = "R4";
    ticks(4);
    check("R4", nmi, 1'b0, "nmi after 4 of 5 ticks");
    ticks(1);
    check("R4", nmi, 1'b1, "nmi after 5 of 5 ticks");

    phase = "R8";
    ticks(9);
    check("R8", rst_req, 1'b0, "rst_req inside grace window");
    check("R8", nmi, 1'b1, "nmi held in grace window");
    phase = "R9";
    ticks(1);
    check("R9", rst_req, 1'b1, "rst_req at grace expiry");
    idle(1);
    check("R9", rst_req, 1'b0, "rst_req one cycle only");
    ticks(20);
    check("R9", rst_req, 1'b0, "no further request after halt");
    check("R9", nmi, 1'b1, "nmi stays after request");

    phase = "R3";
    write(7'h15, 1'b0, 7, 1'b0);
    check("R3", nmi, 1'b1, "wrong key leaves nmi");

    phase = "R7";
    write(7'h6A, 1'b1, 3, 1'b0);
    check("R7", nmi, 1'b0, "service clears nmi");
    ticks(3);
    check("R7", nmi, 1'b1, "next expiry is first stage");
    check("R7", rst_req, 1'b0, "no request after service");

    phase = "R11";
    write(7'h6A, 1'b1, 2, 1'b0);
    check("R11", nmi, 1'b1, "replayed key rejected");
    write(7'h15, 1'b1, 2, 1'b0);
    check("R11", nmi, 1'b0, "inverse of new key accepted");

    phase = "R10";
    idle(4);
    ticks(1);
    idle(3);
    check("R10", nmi, 1'b0, "gaps without tick do not count");
    ticks(1);
    check("R10", nmi, 1'b1, "second tick expires");
    write(7'h6A, 1'b1, 2, 1'b1);
    ticks(1);
    check("R10", nmi, 1'b0, "write wins over same-cycle tick");
    ticks(1);
    check("R10", nmi, 1'b1, "full count after write with tick");

    phase = "R6";
    write(7'h15, 1'b0, 9, 1'b0);
    ticks(300);
    check("R6", nmi, 1'b0, "stopped counter never expires");

    phase = "R5";
    write(7'h33, 1'b1, 0, 1'b0);
    ticks(255);
    check("R5", nmi, 1'b0, "zero count before 256 ticks");
    ticks(1);
    check("R5", nmi, 1'b1, "zero count expires at 256 ticks");

    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule